// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase locked loop has settled. It watches two pulse trains that are already synchronous to a fast sampling clock: the divided reference and the divided feedback. Once per comparison cycle it counts the sampling-clock periods between the first rising edge of either train and the matching rising edge of the other. That count is the phase error. The error is compared against two thresholds, both given in sampling-clock counts. With a 200 MHz sampling clock, counts of 3 and 6 correspond to roughly 15 ns and 30 ns.

The lock indicator is raised only after a run of consecutive cycles with a small error. The `precise` input picks the length of that run: three cycles when low, five cycles when high. A single cycle with a large error clears the indicator at once. A cycle whose error falls between the thresholds leaves the indicator as it is, but restarts the run. The indicator and the run are cleared by the synchronous reset and by a one-cycle initialisation pulse. This detector is meant for the digital lock-detect setting of the synthesizer's function register.

Top module: `pll_lock_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `lock_o` is 0.
- R2: A measured error below TIGHT_CNT counts as a good cycle. With `precise`=0, `lock_o` rises at the clock edge that samples the completing edge of the 3rd consecutive good cycle.
- R3: With `precise`=1, `lock_o` rises at the clock edge that samples the completing edge of the 5th consecutive good cycle, and not earlier.
- R4: A measured error above LOOSE_CNT counts as a bad cycle. It clears `lock_o` and the run at the clock edge that samples the completing edge.
- R5: An error from TIGHT_CNT to LOOSE_CNT inclusive leaves `lock_o` unchanged and restarts the run from zero.
- R6: The error is the number of sampling-clock cycles between the first rising edge of either input and the next rising edge of the other input. Either input may lead. Edges sampled in the same cycle give an error of 0.
- R7: If the partner edge has not arrived MAX_WAIT cycles after the leading edge, the cycle is judged bad at that point.
- R8: A second rising edge of the leading input before its partner arrives counts as a bad cycle, and a new measurement starts from that edge.
- R9: A one-cycle `init_pulse` clears `lock_o` and the run. Afterwards the full run of good cycles is needed again.
- R10: Only rising edges count. An input held high for several cycles gives a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; sets the time resolution |
| rst | input | 1 | Synchronous reset, active high |
| init_pulse | input | 1 | Synchronous clear of the lock state, active high |
| precise | input | 1 | Run-length select: 0 needs 3 good cycles, 1 needs 5 |
| ref_in | input | 1 | Divided reference pulses, synchronous to `clk` |
| fb_in | input | 1 | Divided feedback pulses, synchronous to `clk` |
| lock_o | output | 1 | Lock indicator |

## Verification
The bench goes after the threshold boundaries: errors of 2, 3, 6 and 7 counts. A design that mixed up strict and inclusive comparisons would lock or unlock one step off. It checks that an error between the thresholds restarts the run without touching the indicator. A design that only held the count would lock a cycle or more too early. It also checks that lock rises and falls on the exact clock edge that samples the completing edge, so an extra register stage shows up as a one-cycle lag. Further cases cover a missing partner, a leading input that fires twice, pulses wider than one cycle, and an initialisation pulse in the middle of a locked run. A design that dropped the timeout, counted levels as edges or kept a stale run would hold lock too long or reach it too soon.

// File: rtl/pll_lockdet_pkg.sv
package pll_lockdet_pkg;

    // Verdict for one comparison cycle
    typedef enum logic [1:0] {
        CLS_GOOD = 2'd0,
        CLS_MID  = 2'd1,
        CLS_BAD  = 2'd2
    } phase_cls_e;

    // Measurement state: idle or waiting for the partner edge
    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_WAIT = 1'b1
    } meas_state_e;

endpackage

// File: rtl/pll_edge_meter.sv
module pll_edge_meter
    import pll_lockdet_pkg::*;
#(
    parameter int TIGHT_CNT = 3,
    parameter int LOOSE_CNT = 6,
    parameter int MAX_WAIT  = 40
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       ref_in,
    input  logic       fb_in,
    output logic       res_valid,
    output phase_cls_e res_cls
);
    localparam int CW = $clog2(MAX_WAIT + 1);

    typedef struct packed {
        meas_state_e   st;
        logic          lead_ref;
        logic [CW-1:0] cnt;
        logic          ref_prev;
        logic          fb_prev;
    } meter_t;

    meter_t        m_d, m_q;
    logic          ref_rise, fb_rise, partner, lead_again;
    logic [CW-1:0] err;
    logic          miss;

    always_comb begin
        ref_rise   = ref_in & ~m_q.ref_prev;
        fb_rise    = fb_in & ~m_q.fb_prev;
        partner    = m_q.lead_ref ? fb_rise : ref_rise;
        lead_again = m_q.lead_ref ? ref_rise : fb_rise;
        m_d          = m_q;
        m_d.ref_prev = ref_in;
        m_d.fb_prev  = fb_in;
        res_valid    = 1'b0;
        err          = '0;
        miss         = 1'b0;
        if (m_q.st == MS_IDLE) begin
            if (ref_rise && fb_rise) begin
                res_valid = 1'b1;
            end else if (ref_rise || fb_rise) begin
                m_d.st       = MS_WAIT;
                m_d.lead_ref = ref_rise;
                m_d.cnt      = CW'(1);
            end
        end else begin
            if (partner) begin
                res_valid = 1'b1;
                err       = m_q.cnt;
                m_d.st    = lead_again ? MS_WAIT : MS_IDLE;
                m_d.cnt   = CW'(1);
            end else if (lead_again) begin
                res_valid = 1'b1;
                miss      = 1'b1;
                m_d.cnt   = CW'(1);
            end else if (m_q.cnt == CW'(MAX_WAIT)) begin
                res_valid = 1'b1;
                miss      = 1'b1;
                m_d.st    = MS_IDLE;
            end else begin
                m_d.cnt = m_q.cnt + 1'b1;
            end
        end
        if (miss || err > CW'(LOOSE_CNT)) begin
            res_cls = CLS_BAD;
        end else if (err < CW'(TIGHT_CNT)) begin
            res_cls = CLS_GOOD;
        end else begin
            res_cls = CLS_MID;
        end
        if (clr) begin
            m_d.st       = MS_IDLE;
            m_d.lead_ref = 1'b0;
            m_d.cnt      = '0;
        end
    end

    always_ff @(posedge clk) begin
        m_q <= m_d;
    end

    // Waiting counter stays inside its window
    assert_wait_window_R7: assert property (@(posedge clk) disable iff (clr)
        (m_q.st == MS_WAIT) |-> (m_q.cnt != '0 && m_q.cnt <= CW'(MAX_WAIT)));

    // Window exhausted always yields a verdict
    assert_timeout_verdict_R7: assert property (@(posedge clk) disable iff (clr)
        (m_q.st == MS_WAIT && m_q.cnt == CW'(MAX_WAIT)) |-> res_valid);

    // Coincident edges while idle give a good cycle
    assert_coincident_good_R6: assert property (@(posedge clk) disable iff (clr)
        (m_q.st == MS_IDLE && ref_in && !m_q.ref_prev && fb_in && !m_q.fb_prev)
        |-> (res_valid && res_cls == CLS_GOOD));

    // A re-fired leading edge without partner is judged bad
    assert_refire_bad_R8: assert property (@(posedge clk) disable iff (clr)
        (m_q.st == MS_WAIT && lead_again && !partner) |-> (res_valid && res_cls == CLS_BAD));

endmodule

// File: rtl/pll_lock_judge.sv
module pll_lock_judge
    import pll_lockdet_pkg::*;
#(
    parameter int RUN_LO = 3,
    parameter int RUN_HI = 5
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       precise,
    input  logic       res_valid,
    input  phase_cls_e res_cls,
    output logic       lock
);
    localparam int RW = $clog2(RUN_HI + 1);

    typedef struct packed {
        logic          locked;
        logic [RW-1:0] run;
    } judge_t;

    judge_t        j_d, j_q;
    logic [RW-1:0] need;

    always_comb begin
        need = precise ? RW'(RUN_HI) : RW'(RUN_LO);
        j_d  = j_q;
        if (res_valid) begin
            case (res_cls)
                CLS_GOOD: begin
                    if (j_q.run < RW'(RUN_HI)) begin
                        j_d.run = j_q.run + 1'b1;
                    end
                    if (j_d.run >= need) begin
                        j_d.locked = 1'b1;
                    end
                end
                CLS_MID: begin
                    j_d.run = '0;
                end
                default: begin
                    j_d.run    = '0;
                    j_d.locked = 1'b0;
                end
            endcase
        end
        if (clr) begin
            j_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        j_q <= j_d;
    end

    assign lock = j_q.locked;

    // Lock only rises right after a good verdict
    assert_rise_after_good_R2: assert property (@(posedge clk) disable iff (clr)
        $rose(j_q.locked) |-> $past(res_valid && res_cls == CLS_GOOD));

    // Lock only rises once the selected run length is reached
    assert_rise_needs_run_R3: assert property (@(posedge clk) disable iff (clr)
        $rose(j_q.locked) |-> (j_q.run >= $past(need)));

    // A bad verdict drops lock on the next edge
    assert_bad_drops_R4: assert property (@(posedge clk) disable iff (clr)
        (res_valid && res_cls == CLS_BAD) |=> !j_q.locked);

    // An in-between verdict holds lock and clears the run
    assert_mid_holds_R5: assert property (@(posedge clk) disable iff (clr)
        (res_valid && res_cls == CLS_MID) |=> ($stable(j_q.locked) && j_q.run == '0));

endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector
    import pll_lockdet_pkg::*;
#(
    parameter int TIGHT_CNT = 3,
    parameter int LOOSE_CNT = 6,
    parameter int MAX_WAIT  = 40,
    parameter int RUN_LO    = 3,
    parameter int RUN_HI    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic init_pulse,
    input  logic precise,
    input  logic ref_in,
    input  logic fb_in,
    output logic lock_o
);
    logic       clr;
    logic       res_valid;
    phase_cls_e res_cls;

    assign clr = rst | init_pulse;

    pll_edge_meter #(
        .TIGHT_CNT(TIGHT_CNT),
        .LOOSE_CNT(LOOSE_CNT),
        .MAX_WAIT (MAX_WAIT)
    ) u_meter (
        .clk      (clk),
        .clr      (clr),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .res_valid(res_valid),
        .res_cls  (res_cls)
    );

    pll_lock_judge #(
        .RUN_LO(RUN_LO),
        .RUN_HI(RUN_HI)
    ) u_judge (
        .clk      (clk),
        .clr      (clr),
        .precise  (precise),
        .res_valid(res_valid),
        .res_cls  (res_cls),
        .lock     (lock_o)
    );

    // Initialisation pulse clears lock on the next edge
    assert_init_clears_R9: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> !lock_o);

    // Reset leaves lock low
    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> !lock_o);

endmodule

// File: tb/pll_lock_detector_test.sv
module pll_lock_detector_test;
    localparam int TIGHT = 3;
    localparam int LOOSE = 6;
    localparam int MAXW  = 40;
    localparam int RLO   = 3;
    localparam int RHI   = 5;
    localparam int PER   = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_pulse = 1'b0;
    logic precise = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic lock_o;

    int checks = 0;
    int errors = 0;
    bit exp_lock = 1'b0;
    int exp_run = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_lock_detector #(
        .TIGHT_CNT(TIGHT), .LOOSE_CNT(LOOSE), .MAX_WAIT(MAXW),
        .RUN_LO(RLO), .RUN_HI(RHI)
    ) uut (
        .clk(clk), .rst(rst), .init_pulse(init_pulse), .precise(precise),
        .ref_in(ref_in), .fb_in(fb_in), .lock_o(lock_o)
    );

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // 0 good, 1 in-between, 2 bad
    function automatic int classify(int err, bit miss);
        if (miss || err > LOOSE) return 2;
        if (err < TIGHT) return 0;
        return 1;
    endfunction

    task automatic model(int cls);
        int need;
        need = precise ? RHI : RLO;
        if (cls == 0) begin
            if (exp_run < RHI) exp_run++;
            if (exp_run >= need) exp_lock = 1'b1;
        end else if (cls == 1) begin
            exp_run = 0;
        end else begin
            exp_run = 0;
            exp_lock = 1'b0;
        end
    endtask

    // One comparison period; an offset of -1 means no pulse on that input
    task automatic run_period(string req, int ref_off, int fb_off, int w);
        int comp;
        int err;
        bit miss;
        bit old_lock;
        comp = -1;
        err = 0;
        miss = 1'b0;
        if (ref_off >= 0 && fb_off >= 0) begin
            err  = (ref_off > fb_off) ? ref_off - fb_off : fb_off - ref_off;
            comp = (ref_off > fb_off) ? ref_off : fb_off;
        end else if (ref_off >= 0) begin
            comp = ref_off + MAXW;
            miss = 1'b1;
        end else if (fb_off >= 0) begin
            comp = fb_off + MAXW;
            miss = 1'b1;
        end
        old_lock = exp_lock;
        if (comp >= 0) model(classify(err, miss));
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            ref_in = (ref_off >= 0 && c >= ref_off && c < ref_off + w);
            fb_in  = (fb_off >= 0 && c >= fb_off && c < fb_off + w);
            @(posedge clk);
            #1;
            if (c == comp - 1) check(req, lock_o, old_lock, "one cycle before completing edge");
            if (c == comp) check(req, lock_o, exp_lock, "at completing edge");
            if (comp < 0 && c == PER - 1) check(req, lock_o, old_lock, "period without edges");
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", lock_o, 1'b0, "during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", lock_o, 1'b0, "after reset");

        // R2 / R6: coincident edges, lock on the 3rd good cycle
        precise = 1'b0;
        repeat (3) run_period("R2", 10, 10, 1);
        check("R2", lock_o, 1'b1, "locked after three good cycles");
        // R4: large error drops lock at once
        run_period("R4", 10, 20, 1);
        // R6: feedback leads, error 2 stays good
        repeat (3) run_period("R6", 12, 10, 1);
        // R5 boundaries: 3 and 6 hold lock
        run_period("R5", 10, 13, 1);
        run_period("R5", 16, 10, 1);
        check("R5", lock_o, 1'b1, "in-between errors keep lock");
        // R4 boundary: 7 drops
        run_period("R4", 10, 17, 1);
        // R5: in-between restarts the run
        repeat (2) run_period("R5", 10, 12, 1);
        run_period("R5", 10, 14, 1);
        repeat (2) run_period("R5", 10, 11, 1);
        check("R5", lock_o, 1'b0, "run restarted by in-between error");
        run_period("R5", 10, 11, 1);
        // R3: five cycles needed with precise high
        run_period("R4", 5, 20, 1);
        precise = 1'b1;
        repeat (5) run_period("R3", 10, 11, 1);
        check("R3", lock_o, 1'b1, "locked after five good cycles");
        // R7: missing partner in either direction
        run_period("R7", 10, -1, 1);
        repeat (5) run_period("R3", 10, 10, 1);
        run_period("R7", -1, 8, 1);
        // R9: initialisation pulse
        precise = 1'b0;
        repeat (3) run_period("R2", 10, 10, 1);
        @(negedge clk);
        init_pulse = 1'b1;
        @(posedge clk);
        #1;
        check("R9", lock_o, 1'b0, "init pulse clears lock");
        @(negedge clk);
        init_pulse = 1'b0;
        exp_lock = 1'b0;
        exp_run = 0;
        repeat (3) run_period("R9", 10, 10, 1);
        // R8: leading input fires twice without a partner
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            ref_in = (c == 5 || c == 15);
            fb_in = 1'b0;
            @(posedge clk);
            #1;
            if (c == 14) check("R8", lock_o, 1'b1, "before second leading edge");
            if (c == 15) check("R8", lock_o, 1'b0, "second leading edge is bad");
        end
        exp_lock = 1'b0;
        exp_run = 0;
        // R10: wide pulses count once
        repeat (3) run_period("R10", 10, 11, 3);
        check("R10", lock_o, 1'b1, "wide pulses give single edges");

        // Random mix
        for (int i = 0; i < 150; i++) begin
            int r;
            int d;
            int w;
            if (i % 25 == 0) precise = 1'($urandom_range(0, 1));
            r = int'($urandom_range(0, 99));
            w = int'($urandom_range(1, 3));
            if (r < 60) d = int'($urandom_range(0, 2));
            else if (r < 80) d = int'($urandom_range(3, 6));
            else d = int'($urandom_range(7, 12));
            if ($urandom_range(0, 1) == 1) d = -d;
            if (r >= 95) run_period("R7", -1, 14, w);
            else if (r >= 90 && r < 95 && d > 8) run_period("R7", 14, -1, w);
            else run_period("R10", 14, 14 + d, w);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule